// File: doc/BRIEF.md
# Parallel EEPROM Byte Write Controller

This block sits on the host side of a byte-wide, electrically erasable parallel memory. A single request carrying an address and a data byte makes it perform one complete byte write: it puts the address and the byte on the memory pins and drives the chip-select, write and read strobes low in a fixed order. Every setup, pulse and hold interval is a whole number of clock cycles, worked out from nanosecond parameters and the clock period and always rounded up.

Once the write strobe has ended, the memory runs its own internal programming cycle. The controller waits until that cycle is over and detects the end in one of two ways, chosen per request:

- **Busy-pin mode** watches an active-low busy pin, which is pulled up on the board.
- **Data-poll mode** reads the just-written location again and again until bit 7 of the read value equals bit 7 of the byte that was written. While the memory is still programming, that bit reads back inverted.

When the write completes, the controller gives a one-cycle done pulse. If it waits longer than the timeout limit, it gives a one-cycle timeout pulse instead. The controller takes only one request at a time.

Top module: `eeprom_wr_ctrl`

## Requirements
- R1: After reset, and whenever idle, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, `mem_dq_oe` is low, and `busy`, `done` and `timeout` are low.
- R2: A request taken while idle latches the address and the byte. `mem_ce_n` goes low with the bus driven and `mem_oe_n` high for SU = max(ceil(T_AS/CLK), ceil(T_OES/CLK)) cycles before `mem_we_n` falls. The byte then ends up stored at that address.
- R3: `mem_we_n` stays low for exactly WP = max(ceil(T_WP/CLK), ceil(T_DS/CLK)) cycles. During that time `mem_addr` and `mem_dq_o` stay stable and `mem_oe_n` stays high.
- R4: After `mem_we_n` rises, the address, the driven byte and `mem_ce_n` low are held for exactly HD = max of ceil(T_AH/CLK), ceil(T_DH/CLK) and ceil(T_OEH/CLK) cycles. The bus is then released.
- R5: Completion checking starts DB = ceil(T_DB/CLK) cycles after the hold ends. In data-poll mode, the first read therefore begins HD+DB cycles after `mem_we_n` rises.
- R6: With `poll_mode` = 0 (busy-pin mode), `mem_busy_n` low means busy. `done` pulses two cycles after the first cycle in which `mem_busy_n` is high during the wait. No read strobe is issued.
- R7: With `poll_mode` = 1 (data-poll mode), each poll read works as follows:
  - `mem_ce_n` and `mem_oe_n` stay low for RD = ceil(T_RD/CLK) cycles with the bus not driven.
  - Bit 7 of `mem_dq_i` is sampled in the last of those cycles.
  - An idle gap of OFF = ceil(T_OFF/CLK) cycles follows.
  - If the sampled bit equalled the written bit 7, `done` pulses after the gap; otherwise the next read starts.
- R8: If the write is not complete within TO = ceil(T_TO/CLK) cycles of the start of the wait, `timeout` pulses exactly HD+TO cycles after `mem_we_n` rises. No `done` is given, and the controller returns to idle.
- R9: `req` is ignored while `busy` is high. No second write strobe is issued and no other location is written.
- R10: `done` and `timeout` are single-cycle pulses and never high together. `busy` is low in the cycle in which either pulse is high.
- R11: `poll_mode` is sampled only when a request is accepted. Changing it during a write does not change how completion is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a byte write (acted on only when idle) |
| req_addr | input | AW | Target address |
| req_data | input | 8 | Byte to write |
| poll_mode | input | 1 | 0 = busy-pin completion, 1 = bit-7 data polling |
| busy | output | 1 | A write or its completion wait is in progress |
| done | output | 1 | One-cycle pulse: write completed |
| timeout | output | 1 | One-cycle pulse: completion not seen in time |
| mem_addr | output | AW | Address pins of the memory |
| mem_dq_o | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Data bus as read back from the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_busy_n | input | 1 | Memory busy flag, low while programming |

## Verification
The bench counts clock cycles and records the cycle of every strobe edge, bus release, busy release and result pulse. It then compares the gaps between those cycles with counts it computes itself from the nanosecond parameters:

| Interval | Expected |
|---|---|
| Chip select to write strobe | SU |
| Write strobe width | WP |
| Strobe release to bus release | HD |
| Strobe release to first poll read | HD+DB |
| Strobe release to timeout | HD+TO |

In busy-pin mode, `done` must appear exactly two cycles after the busy pin first reads high. In data-poll mode, `done` must come after the memory model releases and within two gaps plus one read of that release. Every value is sampled on the falling clock edge, halfway between the register updates, so each recorded cycle index is unambiguous.

// File: rtl/eeprom_wr_ctrl.sv
module eeprom_wr_ctrl #(
  parameter int AW        = 13,
  parameter int CLK_NS    = 20,
  parameter int T_AS_NS   = 10,
  parameter int T_AH_NS   = 100,
  parameter int T_DS_NS   = 120,
  parameter int T_DH_NS   = 10,
  parameter int T_WP_NS   = 150,
  parameter int T_OES_NS  = 10,
  parameter int T_OEH_NS  = 10,
  parameter int T_DB_NS   = 50,
  parameter int T_RD_NS   = 300,
  parameter int T_OFF_NS  = 60,
  parameter int T_TO_NS   = 4_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          poll_mode,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [7:0]    mem_dq_i,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  input  logic          mem_busy_n
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_SU  = imax(ns2cyc(T_AS_NS), ns2cyc(T_OES_NS));
  localparam int C_WP  = imax(ns2cyc(T_WP_NS), ns2cyc(T_DS_NS));
  localparam int C_HD  = imax(ns2cyc(T_AH_NS), imax(ns2cyc(T_DH_NS), ns2cyc(T_OEH_NS)));
  localparam int C_DB  = ns2cyc(T_DB_NS);
  localparam int C_RD  = ns2cyc(T_RD_NS);
  localparam int C_OFF = ns2cyc(T_OFF_NS);
  localparam int C_TO  = ns2cyc(T_TO_NS);
  localparam int C_LONG = imax(C_TO, imax(imax(C_SU, C_WP),
                               imax(imax(C_HD, C_DB), imax(C_RD, C_OFF))));
  localparam int CW = $clog2(C_LONG + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_GAP, S_RB, S_RD, S_FLOAT
  } state_t;

  state_t        st;
  logic [CW-1:0] pcnt, tcnt;
  logic [AW-1:0] a_q;
  logic [7:0]    d_q;
  logic          mode_q, match_q, rb_q, done_q, to_q;
  logic          ph_end, waiting, fin, tmo_hit;

  assign ph_end  = (pcnt == '0);
  assign waiting = (st == S_GAP) || (st == S_RB) || (st == S_RD) || (st == S_FLOAT);
  assign fin     = ((st == S_RB) && rb_q) || ((st == S_FLOAT) && ph_end && match_q);
  assign tmo_hit = waiting && !fin && (tcnt == CW'(C_TO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pcnt    <= '0;
      tcnt    <= '0;
      a_q     <= '0;
      d_q     <= '0;
      mode_q  <= 1'b0;
      match_q <= 1'b0;
      rb_q    <= 1'b1;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      rb_q   <= mem_busy_n;
      if (!ph_end) pcnt <= pcnt - 1'b1;
      if (waiting) tcnt <= tcnt + 1'b1;
      case (st)
        S_IDLE: if (req) begin
          a_q    <= req_addr;
          d_q    <= req_data;
          mode_q <= poll_mode;
          st     <= S_SETUP;
          pcnt   <= CW'(C_SU - 1);
        end
        S_SETUP: if (ph_end) begin
          st   <= S_STROBE;
          pcnt <= CW'(C_WP - 1);
        end
        S_STROBE: if (ph_end) begin
          st   <= S_HOLD;
          pcnt <= CW'(C_HD - 1);
        end
        S_HOLD: if (ph_end) begin
          st   <= S_GAP;
          pcnt <= CW'(C_DB - 1);
          tcnt <= '0;
        end
        S_GAP: if (ph_end) begin
          if (mode_q) begin
            st   <= S_RD;
            pcnt <= CW'(C_RD - 1);
          end else begin
            st <= S_RB;
          end
        end
        S_RB: if (fin) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        S_RD: if (ph_end) begin
          match_q <= (mem_dq_i[7] == d_q[7]);
          st      <= S_FLOAT;
          pcnt    <= CW'(C_OFF - 1);
        end
        S_FLOAT: if (ph_end) begin
          if (match_q) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st   <= S_RD;
            pcnt <= CW'(C_RD - 1);
          end
        end
        default: st <= S_IDLE;
      endcase
      if (tmo_hit) begin
        st   <= S_IDLE;
        to_q <= 1'b1;
      end
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign timeout   = to_q;
  assign mem_addr  = a_q;
  assign mem_dq_o  = d_q;
  assign mem_dq_oe = (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);
  assign mem_ce_n  = !(mem_dq_oe || (st == S_RD));
  assign mem_we_n  = (st != S_STROBE);
  assign mem_oe_n  = (st != S_RD);

endmodule

// File: rtl/eeprom_wr_ctrl_chk.sv
module eeprom_wr_ctrl_chk #(
  parameter int AW     = 13,
  parameter int WP_CYC = 8,
  parameter int HD_CYC = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          timeout,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_dq_o,
  input logic          mem_dq_oe,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n
);

  logic [15:0] wlow, hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlow <= '0;
      hcnt <= '0;
    end else begin
      wlow <= !mem_we_n ? wlow + 1'b1 : '0;
      hcnt <= !mem_we_n ? '0 : (mem_dq_oe ? hcnt + 1'b1 : hcnt);
    end
  end

  p_strobe_ctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  p_strobe_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlow == 16'(WP_CYC)));

  p_hold_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> (hcnt == 16'(HD_CYC)));

  p_read_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && mem_we_n && !mem_ce_n));

  p_addr_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));

  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |=> !(done || timeout));

  p_pulse_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> (!busy && $past(busy)));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

bind eeprom_wr_ctrl eeprom_wr_ctrl_chk #(.AW(AW), .WP_CYC(C_WP), .HD_CYC(C_HD)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .timeout(timeout),
  .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
);

// File: tb/eeprom_wr_ctrl_test.sv
module eeprom_wr_ctrl_test;
  localparam int CLK_PERIOD = 20;
  localparam int AW = 8;
  localparam int TO_NS = 8000;

  function automatic int cdiv(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_SU  = mx(cdiv(10), cdiv(10));
  localparam int E_WP  = mx(cdiv(150), cdiv(120));
  localparam int E_HD  = mx(cdiv(100), mx(cdiv(10), cdiv(10)));
  localparam int E_DB  = cdiv(50);
  localparam int E_RD  = cdiv(300);
  localparam int E_OFF = cdiv(60);
  localparam int E_TO  = cdiv(TO_NS);

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, poll_mode = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic busy, done, timeout, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n, mem_busy_n;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_dq_o, mem_dq_i;

  int checks = 0, errors = 0, cyc = 0;

  logic [7:0] mem [256];
  logic we_q = 1'b1, stuck = 1'b0;
  int bcnt = 0, dur = 10, nwr = 0;
  logic [AW-1:0] last_a = '0;
  logic [7:0] last_d = '0;

  logic [AW-1:0] exp_addr;
  logic [7:0] exp_data;
  logic m_we = 1, m_ce = 1, m_oe = 1, m_drv = 0, m_bn = 1, bad = 0;
  int ce_fall, we_fall, we_rise, drv_end, first_rd, rd_len, gap_len, oe_rise;
  int rel_cyc, done_cyc, tmo_cyc, nrd, ndone, ntmo;

  eeprom_wr_ctrl #(.AW(AW), .CLK_NS(CLK_PERIOD), .T_TO_NS(TO_NS)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_data(req_data),
    .poll_mode(poll_mode), .busy(busy), .done(done), .timeout(timeout),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_busy_n(mem_busy_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    we_q <= mem_we_n;
    if (!we_q && mem_we_n && !mem_ce_n && mem_oe_n) begin
      mem[mem_addr] <= mem_dq_o;
      last_a <= mem_addr;
      last_d <= mem_dq_o;
      bcnt <= dur;
      nwr <= nwr + 1;
    end else if (bcnt > 0 && !stuck) begin
      bcnt <= bcnt - 1;
    end
  end

  assign mem_busy_n = (bcnt == 0);
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n)
                  ? ((bcnt != 0 && mem_addr == last_a) ? {~last_d[7], 7'h2A} : mem[mem_addr])
                  : 8'hFF;

  always @(negedge clk) begin
    if (m_ce && !mem_ce_n && mem_dq_oe) ce_fall = cyc;
    if (m_we && !mem_we_n) we_fall = cyc;
    if (!mem_we_n && (mem_addr != exp_addr || mem_dq_o != exp_data)) bad = 1'b1;
    if (!m_we && mem_we_n) we_rise = cyc;
    if (m_drv && !mem_dq_oe) drv_end = cyc;
    if (m_oe && !mem_oe_n) begin
      if (nrd == 0) first_rd = cyc;
      if (nrd == 1) gap_len = cyc - oe_rise;
      nrd++;
    end
    if (!m_oe && mem_oe_n) begin
      if (nrd == 1) rd_len = cyc - first_rd;
      oe_rise = cyc;
    end
    if (!m_bn && mem_busy_n) rel_cyc = cyc;
    if (done) begin done_cyc = cyc; ndone++; end
    if (timeout) begin tmo_cyc = cyc; ntmo++; end
    m_we = mem_we_n; m_ce = mem_ce_n; m_oe = mem_oe_n; m_drv = mem_dq_oe; m_bn = mem_busy_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_write(input logic [AW-1:0] a, input logic [7:0] d, input logic m,
                           input int blen, input logic hang, input logic intrude);
    logic [AW-1:0] xa;
    logic [7:0] xsave;
    int nwr0, w, bound;
    xa = ~a;
    xsave = mem[xa];
    nwr0 = nwr;
    dur = blen; stuck = hang;
    exp_addr = a; exp_data = d; bad = 1'b0;
    ce_fall = -1; we_fall = -1; we_rise = -1; drv_end = -1; first_rd = -1;
    rd_len = -1; gap_len = -1; rel_cyc = -1; done_cyc = -1; tmo_cyc = -1;
    nrd = 0; ndone = 0; ntmo = 0;
    @(negedge clk);
    req = 1'b1; req_addr = a; req_data = d; poll_mode = m;
    @(negedge clk);
    req = 1'b0; req_addr = AW'($urandom); req_data = 8'($urandom); poll_mode = 1'($urandom);
    if (intrude) begin
      repeat (3) @(negedge clk);
      req = 1'b1; req_addr = xa; req_data = ~d; poll_mode = ~m;
      repeat (2) @(negedge clk);
      req = 1'b0;
    end
    w = 0;
    while (done_cyc < 0 && tmo_cyc < 0 && w < 4000) begin
      @(negedge clk);
      w++;
    end
    repeat (2) @(negedge clk);
    chk(w < 4000, "R8 completion or timeout seen", w, 4000);
    chk(we_fall - ce_fall == E_SU, "R2 select-to-strobe cycles", we_fall - ce_fall, E_SU);
    chk(mem[a] == d, "R2 byte stored", int'(mem[a]), int'(d));
    chk(we_rise - we_fall == E_WP, "R3 strobe width", we_rise - we_fall, E_WP);
    chk(!bad, "R3 address/data stable in strobe", int'(bad), 0);
    chk(drv_end - we_rise == E_HD, "R4 hold cycles", drv_end - we_rise, E_HD);
    chk(nwr - nwr0 == 1, "R9 one write strobe", nwr - nwr0, 1);
    if (intrude) chk(mem[xa] == xsave, "R9 ignored request left memory", int'(mem[xa]), int'(xsave));
    chk(!busy, "R10 idle after result", int'(busy), 0);
    if (m) chk(first_rd - we_rise == E_HD + E_DB, "R5 first poll read start",
               first_rd - we_rise, E_HD + E_DB);
    else   chk(nrd == 0, "R11 no read in busy-pin mode", nrd, 0);
    if (m) begin
      chk(rd_len == E_RD, "R7 poll read length", rd_len, E_RD);
      if (nrd > 1) chk(gap_len == E_OFF, "R7 float gap", gap_len, E_OFF);
    end
    if (hang) begin
      chk(tmo_cyc - we_rise == E_HD + E_TO, "R8 timeout cycle", tmo_cyc - we_rise, E_HD + E_TO);
      chk(ndone == 0 && ntmo == 1, "R8 timeout without done", ndone, 0);
      stuck = 1'b0;
      repeat (blen + 2) @(negedge clk);
    end else begin
      chk(ndone == 1 && ntmo == 0, "R10 single done pulse", ndone, 1);
      if (m) begin
        bound = 2 * E_OFF + E_RD + 2;
        chk(done_cyc > rel_cyc && done_cyc - rel_cyc <= bound, "R7 data-poll done latency",
            done_cyc - rel_cyc, bound);
      end else begin
        chk(done_cyc - rel_cyc == 2, "R6 busy-pin done latency", done_cyc - rel_cyc, 2);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes idle after reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    chk(!busy && !done && !timeout, "R1 status low after reset", {busy, done, timeout}, 0);

    run_write(8'h10, 8'h80, 1'b1, 40, 1'b0, 1'b0);
    run_write(8'h11, 8'h7F, 1'b1, 25, 1'b0, 1'b0);
    run_write(8'h12, 8'hC3, 1'b0, 12, 1'b0, 1'b0);
    run_write(8'h13, 8'h00, 1'b0, 30, 1'b0, 1'b1);
    run_write(8'h14, 8'hFF, 1'b1, 60, 1'b0, 1'b1);
    run_write(8'h15, 8'h5A, 1'b0, 20, 1'b1, 1'b0);
    run_write(8'h16, 8'hA5, 1'b1, 20, 1'b1, 1'b0);
    run_write(8'h00, 8'h01, 1'b1, 10, 1'b0, 1'b0);
    run_write(8'hFF, 8'hFE, 1'b0, 10, 1'b0, 1'b0);
    for (int k = 0; k < 30; k++)
      run_write(AW'($urandom), 8'($urandom), 1'($urandom), 10 + int'($urandom % 141),
                1'b0, 1'($urandom % 4 == 0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule